// File: doc/BRIEF.md
# ECC Partial-Store Merge Unit

This unit sits between a store path and a data array. The array keeps 32 data bits plus 7 SECDED check bits for each aligned word. A store carries a word address, 32 bits of data and a 4-bit byte mask. Stores first enter a one-word coalescing buffer. Consecutive narrow stores to the same word collect there. When the buffer covers every byte, it is committed as a plain encoded write and the array is not read.

If a partial word has to be committed, the unit performs a locked three-cycle sequence. It reads the stored code word, corrects a single-bit error, merges the buffered bytes, re-encodes the result and writes it back. An uncorrectable old word stops the write and raises an error pulse instead. New stores stall through the ready/valid handshake until the commit finishes, so no other store can slip between the read and the write.

A separate load port reads the array, checks the syndrome and returns corrected data with single-error and double-error flags.

Top module: `ecc_merge_unit`

## Requirements
- R1: When the buffered mask becomes 4'b1111 with no other flush event, the word is written in the second cycle after the store is accepted, with `mem_re_o` staying low. The written data is the buffered data. A full-mask write also repairs a word that held an uncorrectable error.
- R2: A partial commit drives `mem_re_o` for one cycle and writes two cycles later. The write carries the new bytes where the mask bit is set (mask bit i selects data bits 8i+7..8i) and the old bytes everywhere else.
- R3: Narrow stores to the same word accumulate in the buffer. When together they fill the mask, exactly one write takes place and there is no array read.
- R4: A non-empty store to a different word flushes the held word in the cycle it is accepted, and the new store takes its place in the buffer. Bytes still held in the buffer are not visible to loads.
- R5: A cycle with `drain_i` high while idle flushes a non-empty buffer. `st_ready_o` is low in any cycle where `drain_i` is high.
- R6: `st_ready_o` is high only when no commit is in progress and the buffer is not full. Reset leaves it high.
- R7: During a partial commit, a single-bit error in the old word is corrected before the merge, and the write goes ahead.
- R8: During a partial commit, a double-bit error in the old word suppresses the write. `st_err_o` is raised for one cycle in the slot where the write would have happened.
- R9: A load returns its result one cycle after `ld_valid_i`. The data is corrected, and `ld_sbe_o` is set for a single flipped bit anywhere in the 39-bit code word. In the code word, data sits in bits 31..0 and check bits in 38..32.
- R10: A load of a word with two flipped bits sets `ld_dbe_o` and clears `ld_sbe_o`.
- R11: A store with mask 4'b0000 is accepted and has no effect. It causes no write and no flush.
- R12: After reset, no write, read, error or load-valid output is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| st_valid_i | input | 1 | Store request valid |
| st_ready_o | output | 1 | Store request accepted when high with valid |
| st_addr_i | input | AW | Store word address |
| st_data_i | input | 32 | Store data |
| st_mask_i | input | 4 | Store byte mask |
| drain_i | input | 1 | Flush the coalescing buffer |
| st_err_o | output | 1 | Partial commit aborted on uncorrectable old word |
| ld_valid_i | input | 1 | Load request |
| ld_addr_i | input | AW | Load word address |
| ld_rvalid_o | output | 1 | Load result valid |
| ld_data_o | output | 32 | Corrected load data |
| ld_sbe_o | output | 1 | Load saw a corrected single-bit error |
| ld_dbe_o | output | 1 | Load saw an uncorrectable error |
| mem_re_o | output | 1 | Array read for a partial commit |
| mem_raddr_o | output | AW | Array read address for commits |
| mem_rdata_i | input | 39 | Array read data for commits |
| mem_we_o | output | 1 | Array write enable |
| mem_waddr_o | output | AW | Array write address |
| mem_wdata_o | output | 39 | Array write code word |
| mem_ld_addr_o | output | AW | Array read address for loads |
| mem_ld_rdata_i | input | 39 | Array read data for loads |

## Verification
Results fall due at fixed distances from their trigger:
- A full buffer writes one cycle after it fills, so two cycles after the store is accepted.
- A partial commit reads in the first cycle after launch and writes, or aborts, in the third.
- A load answers one cycle after its request.

A behavioural model in the bench keeps its own buffer, a countdown for the pending commit and a golden copy of the array. At every rising edge it compares ready, read enable, write enable, write address, write data and the error pulse with the values it predicts for that edge. Directed load checks are sampled on the falling edge after the capturing edge.

// File: rtl/ecc_merge_pkg.sv
package ecc_merge_pkg;
  localparam int DW = 32;
  localparam int NB = DW / 8;
  localparam int HW = $clog2(DW) + 1;   // hamming bits
  localparam int CW = HW + 1;           // plus overall parity
  localparam int TW = DW + CW;

  typedef enum logic [2:0] {S_IDLE, S_FULL, S_RD, S_MG, S_WB} fsm_e;

  function automatic logic [HW-1:0] ham_bits(input logic [DW-1:0] d);
    logic [HW-1:0] c;
    logic [$clog2(DW)-1:0] k;
    c = '0;
    k = '0;
    for (int p = 1; p <= DW + HW; p++) begin
      if ((p & (p - 1)) != 0) begin
        for (int i = 0; i < HW; i++)
          if (((p >> i) & 1) == 1) c[i] = c[i] ^ d[k];
        k = k + 1'b1;
      end
    end
    return c;
  endfunction

  function automatic logic [CW-1:0] ecc_chk(input logic [DW-1:0] d);
    logic [HW-1:0] h;
    h = ham_bits(d);
    return {^{d, h}, h};
  endfunction
endpackage

// File: rtl/ecc_enc.sv
module ecc_enc
  import ecc_merge_pkg::*;
(
  input  logic [DW-1:0] d_i,
  output logic [TW-1:0] cw_o
);
  assign cw_o = {ecc_chk(d_i), d_i};
endmodule

// File: rtl/ecc_dec.sv
module ecc_dec
  import ecc_merge_pkg::*;
(
  input  logic [TW-1:0] cw_i,
  output logic [DW-1:0] d_o,
  output logic          sbe_o,
  output logic          dbe_o
);
  logic [HW-1:0] syn;
  logic          par;

  always_comb begin
    logic [$clog2(DW)-1:0] k;
    syn   = ham_bits(cw_i[DW-1:0]) ^ cw_i[DW+HW-1:DW];
    par   = ^cw_i;
    sbe_o = par;
    dbe_o = !par && (syn != '0);
    d_o   = cw_i[DW-1:0];
    k     = '0;
    for (int p = 1; p <= DW + HW; p++) begin
      if ((p & (p - 1)) != 0) begin
        if (par && (p == int'(syn))) d_o[k] = ~d_o[k];
        k = k + 1'b1;
      end
    end
  end
endmodule

// File: rtl/store_coalesce.sv
module store_coalesce
  import ecc_merge_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          put_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  input  logic [NB-1:0] mask_i,
  input  logic          clr_i,
  output logic          vld_o,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] data_o,
  output logic [NB-1:0] mask_o,
  output logic          full_o,
  output logic          hit_o
);
  logic          vld_q;
  logic [AW-1:0] addr_q;
  logic [NB-1:0] mask_q;

  assign hit_o  = vld_q && (addr_q == addr_i);
  assign full_o = &mask_q;
  assign vld_o  = vld_q;
  assign addr_o = addr_q;
  assign mask_o = mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q  <= 1'b0;
      addr_q <= '0;
      mask_q <= '0;
    end else if (put_i) begin
      vld_q  <= 1'b1;
      addr_q <= addr_i;
      mask_q <= (hit_o ? mask_q : '0) | mask_i;
    end else if (clr_i) begin
      vld_q  <= 1'b0;
      mask_q <= '0;
    end
  end

  for (genvar b = 0; b < NB; b++) begin : g_lane
    logic [7:0] lane_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                  lane_q <= '0;
      else if (put_i && mask_i[b])  lane_q <= data_i[8*b +: 8];
    end
    assign data_o[8*b +: 8] = lane_q;
  end
endmodule

// File: rtl/ecc_merge_unit.sv
module ecc_merge_unit
  import ecc_merge_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          st_valid_i,
  output logic          st_ready_o,
  input  logic [AW-1:0] st_addr_i,
  input  logic [DW-1:0] st_data_i,
  input  logic [NB-1:0] st_mask_i,
  input  logic          drain_i,
  output logic          st_err_o,
  input  logic          ld_valid_i,
  input  logic [AW-1:0] ld_addr_i,
  output logic          ld_rvalid_o,
  output logic [DW-1:0] ld_data_o,
  output logic          ld_sbe_o,
  output logic          ld_dbe_o,
  output logic          mem_re_o,
  output logic [AW-1:0] mem_raddr_o,
  input  logic [TW-1:0] mem_rdata_i,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_waddr_o,
  output logic [TW-1:0] mem_wdata_o,
  output logic [AW-1:0] mem_ld_addr_o,
  input  logic [TW-1:0] mem_ld_rdata_i
);
  fsm_e          state_q;
  logic [AW-1:0] job_addr_q;
  logic [DW-1:0] job_data_q;
  logic [NB-1:0] job_mask_q;
  logic [TW-1:0] rd_q, wr_q, ld_cw_q;
  logic          abort_q, ld_rvalid_q;

  logic          cb_vld, cb_full, cb_hit;
  logic [AW-1:0] cb_addr;
  logic [DW-1:0] cb_data;
  logic [NB-1:0] cb_mask;
  logic          idle, st_fire, put, launch;
  logic [DW-1:0] rmw_data, merged, enc_in;
  logic [TW-1:0] enc_cw;
  logic          rmw_sbe, rmw_dbe;

  assign idle       = (state_q == S_IDLE);
  assign st_ready_o = idle && !(cb_vld && cb_full) && !drain_i;
  assign st_fire    = st_valid_i && st_ready_o;
  assign put        = st_fire && (|st_mask_i);
  assign launch     = idle && cb_vld && (cb_full || drain_i || (put && !cb_hit));

  store_coalesce #(.AW(AW)) u_cb (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .put_i  (put),
    .addr_i (st_addr_i),
    .data_i (st_data_i),
    .mask_i (st_mask_i),
    .clr_i  (launch),
    .vld_o  (cb_vld),
    .addr_o (cb_addr),
    .data_o (cb_data),
    .mask_o (cb_mask),
    .full_o (cb_full),
    .hit_o  (cb_hit)
  );

  ecc_dec u_rmw_dec (.cw_i(rd_q), .d_o(rmw_data), .sbe_o(rmw_sbe), .dbe_o(rmw_dbe));

  for (genvar b = 0; b < NB; b++) begin : g_merge
    assign merged[8*b +: 8] = job_mask_q[b] ? job_data_q[8*b +: 8] : rmw_data[8*b +: 8];
  end

  // one encoder serves both full-word launch and the merge step
  assign enc_in = (state_q == S_MG) ? merged : cb_data;
  ecc_enc u_enc (.d_i(enc_in), .cw_o(enc_cw));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= S_IDLE;
      job_addr_q <= '0;
      job_data_q <= '0;
      job_mask_q <= '0;
      rd_q       <= '0;
      wr_q       <= '0;
      abort_q    <= 1'b0;
    end else begin
      case (state_q)
        S_IDLE: if (launch) begin
          job_addr_q <= cb_addr;
          job_data_q <= cb_data;
          job_mask_q <= cb_mask;
          wr_q       <= enc_cw;
          abort_q    <= 1'b0;
          state_q    <= cb_full ? S_FULL : S_RD;
        end
        S_FULL: state_q <= S_IDLE;
        S_RD: begin
          rd_q    <= mem_rdata_i;
          state_q <= S_MG;
        end
        S_MG: begin
          wr_q    <= enc_cw;
          abort_q <= rmw_dbe;
          state_q <= S_WB;
        end
        S_WB:    state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign mem_re_o    = (state_q == S_RD);
  assign mem_raddr_o = job_addr_q;
  assign mem_we_o    = (state_q == S_FULL) || ((state_q == S_WB) && !abort_q);
  assign st_err_o    = (state_q == S_WB) && abort_q;
  assign mem_waddr_o = job_addr_q;
  assign mem_wdata_o = wr_q;

  // load path: capture code word, decode next cycle
  assign mem_ld_addr_o = ld_addr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ld_rvalid_q <= 1'b0;
      ld_cw_q     <= '0;
    end else begin
      ld_rvalid_q <= ld_valid_i;
      if (ld_valid_i) ld_cw_q <= mem_ld_rdata_i;
    end
  end

  assign ld_rvalid_o = ld_rvalid_q;
  ecc_dec u_ld_dec (.cw_i(ld_cw_q), .d_o(ld_data_o), .sbe_o(ld_sbe_o), .dbe_o(ld_dbe_o));
endmodule

// File: rtl/ecc_merge_unit_chk.sv
module ecc_merge_unit_chk
  import ecc_merge_pkg::*;
(
  input logic clk_i,
  input logic rst_ni,
  input logic st_ready_o,
  input logic drain_i,
  input logic mem_we_o,
  input logic mem_re_o,
  input logic st_err_o,
  input logic ld_valid_i,
  input logic ld_rvalid_o,
  input logic ld_sbe_o,
  input logic ld_dbe_o,
  input fsm_e state_q,
  input logic rmw_sbe
);
  AST_WE_STALLS: assert property (@(posedge clk_i) disable iff (!rst_ni) mem_we_o |-> !st_ready_o); // R6
  AST_RE_STALLS: assert property (@(posedge clk_i) disable iff (!rst_ni) mem_re_o |-> !st_ready_o); // R6
  AST_DRAIN_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni) drain_i |-> !st_ready_o); // R5
  AST_RMW_SLOT: assert property (@(posedge clk_i) disable iff (!rst_ni) mem_re_o |-> ##2 (mem_we_o || st_err_o)); // R2
  AST_ERR_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni) st_err_o |-> !mem_we_o); // R8
  AST_ERR_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni) st_err_o |=> !st_err_o); // R8
  AST_SBE_WRITES: assert property (@(posedge clk_i) disable iff (!rst_ni) (state_q == S_MG && rmw_sbe) |=> mem_we_o); // R7
  AST_LD_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni) ld_valid_i |=> ld_rvalid_o); // R9
  AST_LD_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni) ld_rvalid_o |-> !(ld_sbe_o && ld_dbe_o)); // R10
endmodule

bind ecc_merge_unit ecc_merge_unit_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .st_ready_o  (st_ready_o),
  .drain_i     (drain_i),
  .mem_we_o    (mem_we_o),
  .mem_re_o    (mem_re_o),
  .st_err_o    (st_err_o),
  .ld_valid_i  (ld_valid_i),
  .ld_rvalid_o (ld_rvalid_o),
  .ld_sbe_o    (ld_sbe_o),
  .ld_dbe_o    (ld_dbe_o),
  .state_q     (state_q),
  .rmw_sbe     (rmw_sbe)
);

// File: tb/sim_ecc_merge_unit.sv
`timescale 1ns/1ps
module sim_ecc_merge_unit;
  localparam int AW = 4;
  localparam int DEPTH = 1 << AW;

  logic clk, rst_n;
  logic st_valid, st_ready, drain, st_err;
  logic [AW-1:0] st_addr, ld_addr, mem_raddr, mem_waddr, mem_ld_addr;
  logic [31:0] st_data, ld_data;
  logic [3:0] st_mask;
  logic ld_valid, ld_rvalid, ld_sbe, ld_dbe, mem_re, mem_we;
  logic [38:0] mem_rdata, mem_wdata, mem_ld_rdata;
  logic [38:0] phys [DEPTH];

  int n_cmp = 0, n_bad = 0, cyc = 0, n_re = 0, n_we = 0, n_err = 0;
  bit done = 0;

  // reference model state
  logic [31:0] gold [DEPTH];
  int nflip [DEPTH];
  bit m_cbv, m_rmw;
  logic [AW-1:0] m_cba, m_ja;
  logic [31:0] m_cbd, m_jd;
  logic [3:0] m_cbm, m_jm;
  int m_cnt;

  ecc_merge_unit #(.AW(AW)) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .st_valid_i(st_valid), .st_ready_o(st_ready), .st_addr_i(st_addr),
    .st_data_i(st_data), .st_mask_i(st_mask), .drain_i(drain), .st_err_o(st_err),
    .ld_valid_i(ld_valid), .ld_addr_i(ld_addr), .ld_rvalid_o(ld_rvalid),
    .ld_data_o(ld_data), .ld_sbe_o(ld_sbe), .ld_dbe_o(ld_dbe),
    .mem_re_o(mem_re), .mem_raddr_o(mem_raddr), .mem_rdata_i(mem_rdata),
    .mem_we_o(mem_we), .mem_waddr_o(mem_waddr), .mem_wdata_o(mem_wdata),
    .mem_ld_addr_o(mem_ld_addr), .mem_ld_rdata_i(mem_ld_rdata)
  );

  assign mem_rdata    = phys[mem_raddr];
  assign mem_ld_rdata = phys[mem_ld_addr];

  initial begin
    clk = 0;
    forever #4 clk = ~clk;
  end

  always @(posedge clk) if (mem_we) phys[mem_waddr] <= mem_wdata;

  function automatic logic [31:0] mrg(input logic [31:0] o, input logic [31:0] n, input logic [3:0] m);
    logic [31:0] r;
    r = o;
    for (int b = 0; b < 4; b++) if (m[b]) r[8*b +: 8] = n[8*b +: 8];
    return r;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  // cycle-by-cycle model
  always @(posedge clk) begin
    bit e_we, e_err, e_rdy, fire, launch, bad_old;
    logic [31:0] e_wd;
    string tag;
    if (!rst_n) begin
      m_cbv = 0; m_cbm = '0; m_cnt = 0; m_rmw = 0;
    end else begin
      cyc++;
      if (cyc > 60000) begin
        n_bad++;
        $display("FAIL R6 watchdog expired actual=%0d expected=<60000", cyc);
        finish_run();
      end
      if (mem_re) n_re++;
      if (mem_we) n_we++;
      if (st_err) n_err++;
      bad_old = m_rmw && (nflip[m_ja] >= 2);
      e_we  = (m_cnt == 1) && !bad_old;
      e_err = (m_cnt == 1) && bad_old;
      tag = !m_rmw ? "R1" : (e_err ? "R8" : (nflip[m_ja] == 1 ? "R7" : "R2"));
      e_wd = m_rmw ? mrg(gold[m_ja], m_jd, m_jm) : m_jd;
      check(mem_we == e_we, tag, 64'(mem_we), 64'(e_we));
      check(st_err == e_err, "R8", 64'(st_err), 64'(e_err));
      check(mem_re == (m_cnt == 3), "R2", 64'(mem_re), 64'(m_cnt == 3));
      if (e_we && mem_we) begin
        check(mem_waddr == m_ja, tag, 64'(mem_waddr), 64'(m_ja));
        check(mem_wdata[31:0] == e_wd, tag, 64'(mem_wdata[31:0]), 64'(e_wd));
      end
      if (e_we) begin
        gold[m_ja] = e_wd;
        nflip[m_ja] = 0;
      end
      e_rdy = (m_cnt == 0) && !(m_cbv && m_cbm == 4'hF) && !drain;
      check(st_ready == e_rdy, "R6", 64'(st_ready), 64'(e_rdy));
      fire   = st_valid && e_rdy && (st_mask != 4'h0);
      launch = (m_cnt == 0) && m_cbv && (m_cbm == 4'hF || drain || (fire && st_addr != m_cba));
      if (m_cnt > 0) m_cnt--;
      if (launch) begin
        m_ja = m_cba; m_jd = m_cbd; m_jm = m_cbm;
        m_rmw = (m_cbm != 4'hF);
        m_cnt = m_rmw ? 3 : 1;
      end
      if (fire) begin
        if (!(m_cbv && st_addr == m_cba)) m_cbm = '0;
        m_cbd = mrg(m_cbd, st_data, st_mask);
        m_cbm = m_cbm | st_mask;
        m_cba = st_addr;
        m_cbv = 1;
      end else if (launch) begin
        m_cbv = 0;
        m_cbm = '0;
      end
    end
  end

  task automatic store(input logic [AW-1:0] a, input logic [31:0] d, input logic [3:0] m);
    st_valid = 1; st_addr = a; st_data = d; st_mask = m;
    while (!st_ready) @(negedge clk);
    @(negedge clk);
    st_valid = 0;
  endtask

  task automatic do_drain();
    repeat (4) @(negedge clk);
    drain = 1;
    @(negedge clk);
    drain = 0;
    repeat (4) @(negedge clk);
  endtask

  task automatic idle();
    repeat (6) @(negedge clk);
  endtask

  task automatic do_load(input logic [AW-1:0] a, input logic [31:0] ed, input bit es, input bit edb, input string tag);
    ld_valid = 1; ld_addr = a;
    @(negedge clk);
    ld_valid = 0;
    check(ld_rvalid == 1'b1, tag, 64'(ld_rvalid), 64'd1);
    check(ld_sbe == es, tag, 64'(ld_sbe), 64'(es));
    check(ld_dbe == edb, tag, 64'(ld_dbe), 64'(edb));
    if (!edb) check(ld_data == ed, tag, 64'(ld_data), 64'(ed));
  endtask

  task automatic inject(input logic [AW-1:0] a, input int bitpos);
    phys[a][bitpos] = ~phys[a][bitpos];
    nflip[a]++;
  endtask

  initial begin
    int re0, we0, er0;
    logic [31:0] r;
    for (int i = 0; i < DEPTH; i++) begin
      phys[i] = '0; gold[i] = '0; nflip[i] = 0;
    end
    rst_n = 0; st_valid = 0; st_addr = '0; st_data = '0; st_mask = '0;
    drain = 0; ld_valid = 0; ld_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R12 reset state
    check(st_ready == 1'b1, "R12", 64'(st_ready), 64'd1);
    check(mem_we == 1'b0 && mem_re == 1'b0, "R12", 64'({mem_we, mem_re}), 64'd0);
    check(st_err == 1'b0 && ld_rvalid == 1'b0, "R12", 64'({st_err, ld_rvalid}), 64'd0);

    // R1 full word, no read
    re0 = n_re;
    store(4'd1, 32'h11223344, 4'hF);
    idle();
    check(n_re == re0, "R1", 64'(n_re), 64'(re0));
    do_load(4'd1, 32'h11223344, 0, 0, "R1");

    // R2 partial store through read-modify-write
    re0 = n_re;
    store(4'd1, 32'hAABBCCDD, 4'b0010);
    do_drain();
    check(n_re == re0 + 1, "R2", 64'(n_re), 64'(re0 + 1));
    do_load(4'd1, 32'h1122CC44, 0, 0, "R2");

    // R3 coalesce two halves into one full write
    re0 = n_re; we0 = n_we;
    store(4'd2, 32'h00005566, 4'b0011);
    store(4'd2, 32'h77880000, 4'b1100);
    idle();
    check(n_re == re0, "R3", 64'(n_re), 64'(re0));
    check(n_we == we0 + 1, "R3", 64'(n_we), 64'(we0 + 1));
    do_load(4'd2, 32'h77885566, 0, 0, "R3");

    // R4 different word flushes held one
    store(4'd3, 32'h00000099, 4'b0001);
    store(4'd4, 32'h00000042, 4'b0001);
    idle();
    do_load(4'd3, 32'h00000099, 0, 0, "R4");
    do_load(4'd4, 32'h00000000, 0, 0, "R4");
    do_drain();
    do_load(4'd4, 32'h00000042, 0, 0, "R5");

    // R11 empty mask: no write, no flush
    store(4'd5, 32'h00330000, 4'b0100);
    we0 = n_we;
    store(4'd6, 32'hFFFFFFFF, 4'b0000);
    idle();
    check(n_we == we0, "R11", 64'(n_we), 64'(we0));
    do_load(4'd6, 32'h00000000, 0, 0, "R11");
    do_load(4'd5, 32'h00000000, 0, 0, "R11");
    do_drain();
    do_load(4'd5, 32'h00330000, 0, 0, "R5");

    // R9 / R7 single-bit error corrected on load and during merge
    inject(4'd1, 5);
    do_load(4'd1, 32'h1122CC44, 1, 0, "R9");
    store(4'd1, 32'hEE000000, 4'b1000);
    do_drain();
    do_load(4'd1, 32'hEE22CC44, 0, 0, "R7");

    // R10 / R8 double-bit error
    inject(4'd2, 3);
    inject(4'd2, 20);
    do_load(4'd2, 32'h0, 0, 1, "R10");
    we0 = n_we; er0 = n_err;
    store(4'd2, 32'h00000001, 4'b0001);
    do_drain();
    check(n_err == er0 + 1, "R8", 64'(n_err), 64'(er0 + 1));
    check(n_we == we0, "R8", 64'(n_we), 64'(we0));
    do_load(4'd2, 32'h0, 0, 1, "R8");
    store(4'd2, 32'hCAFEF00D, 4'hF);
    idle();
    do_load(4'd2, 32'hCAFEF00D, 0, 0, "R1");

    // R9 flips in check bits and overall parity
    inject(4'd3, 33);
    do_load(4'd3, 32'h00000099, 1, 0, "R9");
    inject(4'd4, 38);
    do_load(4'd4, 32'h00000042, 1, 0, "R9");

    // mixed traffic against the model
    r = 32'h1234ABCD;
    for (int i = 0; i < 300; i++) begin
      r = r * 32'd1103515245 + 32'd12345;
      store(4'(8 + r[17:16]), r ^ (r << 7), r[23:20]);
      if (r[27:25] == 3'd0) do_drain();
    end
    do_drain();
    for (int a = 0; a < DEPTH; a++)
      do_load(4'(a), gold[a], nflip[a] == 1, nflip[a] >= 2, "R2");

    finish_run();
  end
endmodule